// File: doc/BRIEF.md
# Prioritized Interrupt Sequencer

This block decides, for a small 8-bit processor core, whether an interrupt is entered at each instruction boundary and which source is served. It latches request pulses from three maskable hardware sources (external pin, timer, serial port). Each source has its own enable bit. The block also tracks one software-interrupt instruction that the mask does not block. It owns the interrupt-mask bit and a reset-time inhibit bit.

The decoder, the stack transfers and the vector fetch live in the core. The core tells the sequencer when an instruction completes, when a software interrupt was fetched, and when a return-from-interrupt restores the stacked mask. The sequencer answers with a one-cycle take strobe and a vector index. No data stream crosses the block, so every pin is a plain control or status signal with no valid/ready pairing and no back-pressure.

Hardware source index i maps to pin bit i: bit 0 is the external pin, bit 1 the timer and bit 2 the serial port. A lower index has higher priority.

Top module: `irq_sequencer`

## Requirements
- R1: Under and after reset, `take`=0, `vec`=0, `imask`=1, `inhibit`=1 and all source enables are 0. No hardware request is served until it is enabled by a write to `en_wdata`.
- R2: Interrupts are decided only on a cycle with `insn_done`=1. `take` is high for exactly the next cycle. `vec` changes only together with `take` and holds its value otherwise.
- R3: A hardware source is served only when its enable bit is 1 and both `imask` and `inhibit` are 0. Otherwise its request stays latched.
- R4: Among eligible hardware sources, the external pin (vec=1) wins over the timer (vec=2), and the timer wins over the serial port (vec=3).
- R5: The cycle `take` is high, `imask` reads 1, and the pending latch of the served hardware source is cleared.
- R6: `rti_done` loads `imask` from `rti_mask`. `mask_clr` clears `imask`. On the same edge, entry wins over `rti_done`, and `rti_done` wins over `mask_clr`.
- R7: A `swi_fetch` pulse makes the software interrupt pending. It is served with vec=0 at a later boundary whatever `imask` is.
- R8: While a software interrupt is pending, only hardware requests that were latched, enabled and unmasked before its fetch can be served ahead of it. Requests latched after the fetch wait until after its entry.
- R9: `inhibit` is set only by reset and cleared by an `inhibit_clr` pulse. While it is set, nothing is taken, software interrupt included, and requests stay latched.
- R10: `en_wr` replaces all enable bits with `en_wdata`. Clearing an enable bit does not drop the latched request of that source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hw_req | input | N_HW | Request pulses; bit 0 external pin, 1 timer, 2 serial |
| en_wr | input | 1 | Write strobe for the enable bits |
| en_wdata | input | N_HW | New enable bits |
| mask_clr | input | 1 | Clear-mask instruction executed |
| inhibit_clr | input | 1 | Software write clearing the inhibit bit |
| insn_done | input | 1 | Current instruction completes this cycle |
| swi_fetch | input | 1 | Software-interrupt instruction fetched |
| rti_done | input | 1 | Return-from-interrupt restores the mask |
| rti_mask | input | 1 | Mask value popped from the stack |
| take | output | 1 | One-cycle interrupt entry strobe |
| vec | output | VW | Vector index: 0 software, 1 pin, 2 timer, 3 serial |
| imask | output | 1 | Current interrupt-mask bit |
| inhibit | output | 1 | Reset-time inhibit bit |

## Verification
The bench builds the block with its default of three hardware sources. This fills the 2-bit vector field exactly, so every vector code and both priority comparisons are reachable. A snapshot taken at software-interrupt fetch can then hold pending and late sources together, which brings the deferral case of R8 within reach. Random request, boundary, mask and return traffic runs against a bench model, alongside directed cases for reset, inhibit and ordering.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  parameter int NUM_HW = 3;
  localparam int VEC_W = $clog2(NUM_HW + 1);
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] clr,
  input  logic         swi_fetch,
  input  logic         swi_take,
  output logic [N-1:0] pend,
  output logic [N-1:0] snap,
  output logic         swi_pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= '0;
      snap     <= '0;
      swi_pend <= 1'b0;
    end else begin
      pend <= (pend & ~clr) | req;
      if (swi_fetch && !swi_pend) begin
        swi_pend <= 1'b1;
        snap     <= pend;
      end else if (swi_take) begin
        swi_pend <= 1'b0;
        snap     <= '0;
      end else begin
        snap <= snap & ~clr;
      end
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N  = 3,
  parameter int VW = 2
) (
  input  logic [N-1:0]  pend,
  input  logic [N-1:0]  snap,
  input  logic [N-1:0]  en,
  input  logic          swi_pend,
  input  logic          imask,
  input  logic          inhibit,
  input  logic          boundary,
  output logic          fire,
  output logic          swi_take,
  output logic [N-1:0]  hw_clr,
  output logic [VW-1:0] pick_vec
);
  logic [N-1:0] cand;
  logic [N-1:0] order_ok;
  logic         hw_any;

  assign order_ok = swi_pend ? snap : {N{1'b1}};
  assign cand     = pend & en & order_ok & {N{~imask}};
  assign hw_any   = |cand;

  always_comb begin
    hw_clr   = '0;
    pick_vec = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        hw_clr   = '0;
        hw_clr[i] = 1'b1;
        pick_vec = VW'(i + 1);
      end
    end
    if (!(boundary && !inhibit && hw_any)) hw_clr = '0;
  end

  assign swi_take = boundary && !inhibit && !hw_any && swi_pend;
  assign fire     = boundary && !inhibit && (hw_any || swi_pend);
endmodule

// File: rtl/irq_mask_ctl.sv
module irq_mask_ctl #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enter,
  input  logic         rti_done,
  input  logic         rti_mask,
  input  logic         mask_clr,
  input  logic         inhibit_clr,
  input  logic         en_wr,
  input  logic [N-1:0] en_wdata,
  output logic         imask,
  output logic         inhibit,
  output logic [N-1:0] en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imask   <= 1'b1;
      inhibit <= 1'b1;
      en      <= '0;
    end else begin
      if (enter)         imask <= 1'b1;
      else if (rti_done) imask <= rti_mask;
      else if (mask_clr) imask <= 1'b0;
      if (inhibit_clr) inhibit <= 1'b0;
      if (en_wr)       en <= en_wdata;
    end
  end
endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer #(
  parameter int N_HW = irq_seq_pkg::NUM_HW,
  localparam int VW  = $clog2(N_HW + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_HW-1:0] hw_req,
  input  logic            en_wr,
  input  logic [N_HW-1:0] en_wdata,
  input  logic            mask_clr,
  input  logic            inhibit_clr,
  input  logic            insn_done,
  input  logic            swi_fetch,
  input  logic            rti_done,
  input  logic            rti_mask,
  output logic            take,
  output logic [VW-1:0]   vec,
  output logic            imask,
  output logic            inhibit
);
  logic [N_HW-1:0] pend, snap, en, hw_clr;
  logic            swi_pend, swi_take, fire;
  logic [VW-1:0]   pick_vec;

  irq_pend_bank #(.N(N_HW)) u_pend (
    .clk(clk), .rst_n(rst_n), .req(hw_req), .clr(hw_clr),
    .swi_fetch(swi_fetch), .swi_take(swi_take),
    .pend(pend), .snap(snap), .swi_pend(swi_pend)
  );

  irq_pick #(.N(N_HW), .VW(VW)) u_pick (
    .pend(pend), .snap(snap), .en(en), .swi_pend(swi_pend),
    .imask(imask), .inhibit(inhibit), .boundary(insn_done),
    .fire(fire), .swi_take(swi_take), .hw_clr(hw_clr), .pick_vec(pick_vec)
  );

  irq_mask_ctl #(.N(N_HW)) u_mask (
    .clk(clk), .rst_n(rst_n), .enter(fire), .rti_done(rti_done),
    .rti_mask(rti_mask), .mask_clr(mask_clr), .inhibit_clr(inhibit_clr),
    .en_wr(en_wr), .en_wdata(en_wdata),
    .imask(imask), .inhibit(inhibit), .en(en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take <= 1'b0;
      vec  <= '0;
    end else begin
      take <= fire;
      if (fire) vec <= pick_vec;
    end
  end
endmodule

// File: rtl/irq_sequencer_chk.sv
module irq_sequencer_chk #(
  parameter int N_HW = 3,
  parameter int VW   = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          insn_done,
  input logic          rti_done,
  input logic          rti_mask,
  input logic          take,
  input logic [VW-1:0] vec,
  input logic          imask,
  input logic          inhibit
);
  p_take_after_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(insn_done));
  p_vec_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !take |-> $stable(vec));
  p_entry_masks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> imask);
  p_hw_needs_unmasked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && vec != '0) |-> $past(!imask));
  p_inhibit_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(!inhibit));
  p_inhibit_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !inhibit |=> !inhibit);
  p_rti_restores_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rti_done |=> (take || imask == $past(rti_mask)));
  p_vec_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(vec) <= N_HW);
endmodule

bind irq_sequencer irq_sequencer_chk #(.N_HW(N_HW), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .rti_done(rti_done),
  .rti_mask(rti_mask), .take(take), .vec(vec), .imask(imask), .inhibit(inhibit)
);

// File: tb/irq_sequencer_test.sv
`timescale 1ns/1ps
module irq_sequencer_test;
  localparam int N  = 3;
  localparam int VW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] hw_req = '0, en_wdata = '0;
  logic en_wr = 0, mask_clr = 0, inhibit_clr = 0, insn_done = 0;
  logic swi_fetch = 0, rti_done = 0, rti_mask = 0;
  logic take, imask, inhibit;
  logic [VW-1:0] vec;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [N-1:0] m_pend, m_en, m_snap;
  logic m_swi, m_mask, m_inh, m_take;
  logic [VW-1:0] m_vec;

  always #2 clk = ~clk;

  irq_sequencer uut (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .en_wr(en_wr), .en_wdata(en_wdata),
    .mask_clr(mask_clr), .inhibit_clr(inhibit_clr), .insn_done(insn_done),
    .swi_fetch(swi_fetch), .rti_done(rti_done), .rti_mask(rti_mask),
    .take(take), .vec(vec), .imask(imask), .inhibit(inhibit)
  );

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic [N-1:0] cand, clr, pend_n, snap_n, en_n;
    logic swi_tk, hw_tk, swi_n, mask_n, inh_n;
    int pick;
    cand = m_pend & m_en & {N{~m_mask}} & (m_swi ? m_snap : {N{1'b1}});
    pick = -1;
    for (int i = N - 1; i >= 0; i--) if (cand[i]) pick = i;
    clr = '0; swi_tk = 0; hw_tk = 0;
    if (insn_done && !m_inh) begin
      if (pick >= 0) begin hw_tk = 1; clr[pick] = 1'b1; end
      else if (m_swi) swi_tk = 1;
    end
    pend_n = (m_pend & ~clr) | hw_req;
    if (swi_fetch && !m_swi) begin swi_n = 1; snap_n = m_pend; end
    else if (swi_tk) begin swi_n = 0; snap_n = '0; end
    else begin swi_n = m_swi; snap_n = m_snap & ~clr; end
    if (hw_tk || swi_tk) mask_n = 1;
    else if (rti_done) mask_n = rti_mask;
    else if (mask_clr) mask_n = 0;
    else mask_n = m_mask;
    inh_n = inhibit_clr ? 1'b0 : m_inh;
    en_n  = en_wr ? en_wdata : m_en;
    m_take = hw_tk || swi_tk;
    if (hw_tk) m_vec = VW'(pick + 1);
    else if (swi_tk) m_vec = '0;
    m_pend = pend_n; m_snap = snap_n; m_swi = swi_n;
    m_mask = mask_n; m_inh = inh_n; m_en = en_n;
  endtask

  task automatic compare(string tag);
    chk(tag, "take", take, m_take);
    chk(tag, "vec", vec, m_vec);
    chk(tag, "imask", imask, m_mask);
    chk(tag, "inhibit", inhibit, m_inh);
  endtask

  task automatic step(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    hw_req = '0; en_wr = 0; mask_clr = 0; inhibit_clr = 0; insn_done = 0;
    swi_fetch = 0; rti_done = 0; rti_mask = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_pend = '0; m_en = '0; m_snap = '0; m_swi = 0;
    m_mask = 1; m_inh = 1; m_take = 0; m_vec = '0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    step("R1");
    // R1: enables cleared, nothing served even when unmasked
    mask_clr = 1; step("R1");
    inhibit_clr = 1; step("R1");
    hw_req = 3'b111; step("R1");
    insn_done = 1; step("R1");
    step("R1");
    // R9: inhibit blocks even enabled unmasked requests and the software interrupt
    rst_n = 1'b0; @(negedge clk);
    m_pend = '0; m_en = '0; m_snap = '0; m_swi = 0;
    m_mask = 1; m_inh = 1; m_take = 0; m_vec = '0;
    rst_n = 1'b1;
    en_wr = 1; en_wdata = 3'b111; mask_clr = 1; hw_req = 3'b001; step("R9");
    swi_fetch = 1; step("R9");
    insn_done = 1; step("R9");
    inhibit_clr = 1; step("R9");
    insn_done = 1; step("R9");
    step("R5");
    insn_done = 1; step("R7");
    step("R7");
    // R4: all three pending, served in order
    hw_req = 3'b111; mask_clr = 1; step("R4");
    insn_done = 1; step("R4");
    mask_clr = 1; step("R4");
    insn_done = 1; step("R4");
    mask_clr = 1; step("R4");
    insn_done = 1; step("R4");
    step("R5");
    // R6: restore from stack value
    rti_done = 1; rti_mask = 0; step("R6");
    rti_done = 1; rti_mask = 1; step("R6");
    rti_done = 1; rti_mask = 1; mask_clr = 1; step("R6");
    // R3 and R10: disabled source keeps its latch
    mask_clr = 1; en_wr = 1; en_wdata = 3'b110; hw_req = 3'b001; step("R10");
    insn_done = 1; step("R3");
    step("R3");
    en_wr = 1; en_wdata = 3'b111; step("R10");
    insn_done = 1; step("R10");
    step("R10");
    // R7: software interrupt with mask set
    swi_fetch = 1; step("R7");
    insn_done = 1; step("R7");
    step("R7");
    // R8: timer pending at fetch first, pin arriving later deferred
    mask_clr = 1; hw_req = 3'b010; step("R8");
    swi_fetch = 1; step("R8");
    hw_req = 3'b001; step("R8");
    insn_done = 1; step("R8");
    insn_done = 1; step("R8");
    mask_clr = 1; step("R8");
    insn_done = 1; step("R8");
    step("R8");
    // R8: late arrival, nothing pending at fetch
    mask_clr = 1; swi_fetch = 1; step("R8");
    hw_req = 3'b100; step("R8");
    insn_done = 1; step("R8");
    mask_clr = 1; step("R8");
    insn_done = 1; step("R8");
    // R2: random traffic
    for (int k = 0; k < 3000; k++) begin
      hw_req      = ($urandom % 4 == 0) ? N'($urandom) : '0;
      insn_done   = ($urandom % 3 == 0);
      en_wr       = ($urandom % 40 == 0);
      en_wdata    = ($urandom % 4 == 0) ? N'($urandom) : {N{1'b1}};
      mask_clr    = ($urandom % 6 == 0);
      rti_done    = ($urandom % 10 == 0);
      rti_mask    = $urandom % 2;
      swi_fetch   = (!m_swi && !insn_done && ($urandom % 15 == 0));
      step("R2");
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule